// File: doc/BRIEF.md
# Coefficient Dequantizer Datapath

This block rebuilds transform coefficients from their quantized levels for a block-based video decoder. Each clock it accepts one quantized coefficient, already in inverse-scan order, together with the matching scaled weight, which is the quantizer scale times the matrix entry and is computed upstream. Three clocks later it delivers one reconstructed 12-bit coefficient. The chain has four steps in order. First a pre-scale step, chosen by macroblock mode. Then a multiply by the weight and a division by 16 that truncates toward zero. Next, any even result is nudged one step toward zero so that it becomes odd. Last, the result saturates to the 12-bit signed range.

A mode register holds intra or non-intra. It is loaded by a one-cycle strobe at the start of each macroblock and stays constant for all of that macroblock's blocks. A DC flag travels with the first coefficient of each block. In intra mode that coefficient bypasses the arithmetic, so the DC predictor downstream can combine it with its prediction. The flag is also delayed to the output for that predictor's use. There is no back-pressure: a valid input always produces a valid output a fixed number of cycles later.

Top module: `coef_dequant`

## Requirements
- R1: In intra mode (mode register = 1) a non-DC coefficient c is reconstructed from the pre-scaled value 2*c.
- R2: In non-intra mode (mode register = 0) the pre-scaled value is 2*c + sign(c), where sign is +1, 0 or -1. The DC flag has no effect in this mode.
- R3: The pre-scaled value is multiplied by in_weight, and the product is divided by 16 with truncation toward zero. For example, a product of -66 yields -4, not -5.
- R4: A nonzero quotient that is even is moved one step toward zero (q - sign(q)). An odd quotient is kept.
- R5: The final value saturates to the range -2048 to +2047.
- R6: mode_load = 1 copies mode_intra into the mode register at the clock edge. The new mode applies to coefficients presented from the next cycle on. Without mode_load the mode register holds its value.
- R7: In intra mode, a coefficient with in_dc = 1 appears at out_coef unchanged, sign-extended to 12 bits.
- R8: A zero coefficient gives a zero output in both modes, whatever the weight.
- R9: out_valid and out_dc repeat in_valid and in_dc exactly 3 cycles later, and out_coef belongs to the same coefficient.
- R10: While rst_n is low, out_valid, out_dc and out_coef are 0 and the mode register is non-intra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_load | input | 1 | Strobe that loads the macroblock mode |
| mode_intra | input | 1 | Mode value to load: 1 intra, 0 non-intra |
| in_valid | input | 1 | Coefficient and weight are valid this cycle |
| in_dc | input | 1 | Marks the first (DC) coefficient of a block |
| in_coef | input | 8 | Quantized coefficient, two's complement |
| in_weight | input | 16 | Scaled weight, unsigned (scale x matrix entry) |
| out_valid | output | 1 | Reconstructed coefficient is valid |
| out_dc | output | 1 | Delayed DC marker |
| out_coef | output | 12 | Reconstructed coefficient, two's complement |

## Verification
The bench aims at negative products whose exact quotient has a fraction. A datapath that divided with an arithmetic shift would round those away from zero and land one step off, often with the wrong parity. It drives quotients that come out exactly even, such as 2 and -4, where a missing or wrongly signed odd-forcing step would return the even value or step away from zero. It pushes the largest levels against the largest weights at both signs to catch saturation bounds that are off by one or that wrap. It also interleaves mode changes with DC-marked coefficients. A design that applied the new mode in the wrong cycle, or let the DC bypass leak into non-intra mode, would then produce the wrong pre-scale or an unscaled level.

// File: rtl/dq_pkg.sv
// Package dq_pkg
// Shared types and fixed constants for the coefficient dequantizer.
// Assumes: nothing beyond IEEE 1800-2017.
package dq_pkg;

    // Reconstruction mode of the current macroblock
    typedef enum logic {
        DQ_NONINTRA = 1'b0,
        DQ_INTRA    = 1'b1
    } dq_mode_e;

    // Division by 16 is a right shift of the magnitude by this amount
    localparam int DQ_DIV_SHIFT = 4;

    // Pipeline depth from input to output, in cycles
    localparam int DQ_LATENCY = 3;

endpackage

// File: rtl/dq_prescale.sv
// Module dq_prescale (pipeline stage 1)
// Forms the pre-scaled level: 2c in intra mode, or 2c+sign(c) in non-intra
// (dead-zone) mode. Splits it into sign and magnitude for the unsigned
// multiplier. Flags the intra DC bypass.
// Assumes: the mode input is stable for the whole macroblock.
module dq_prescale
    import dq_pkg::*;
#(
    parameter int COEF_W = 8,
    parameter int WGT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  dq_mode_e                mode,
    input  logic                    in_valid,
    input  logic                    in_dc,
    input  logic signed [COEF_W-1:0] in_coef,
    input  logic [WGT_W-1:0]        in_weight,
    output logic                    s1_valid,
    output logic                    s1_dc,
    output logic                    s1_pass,
    output logic                    s1_neg,
    output logic [COEF_W:0]         s1_mag,
    output logic [WGT_W-1:0]        s1_wgt,
    output logic [COEF_W-1:0]       s1_coef
);

    localparam int PRE_W = COEF_W + 2;   // room for 2c +/- 1

    logic signed [PRE_W-1:0] coef_ext;
    logic signed [PRE_W-1:0] sign_term;
    logic signed [PRE_W-1:0] pre_val;
    logic                    pre_neg;
    logic [PRE_W-1:0]        pre_abs;

    // Pre-scale the level according to the macroblock mode
    always_comb begin
        coef_ext = PRE_W'(in_coef);
        if (in_coef == '0)
            sign_term = '0;
        else if (in_coef[COEF_W-1])
            sign_term = -PRE_W'(1);
        else
            sign_term = PRE_W'(1);
        if (mode == DQ_INTRA)
            pre_val = coef_ext + coef_ext;
        else
            pre_val = coef_ext + coef_ext + sign_term;
        pre_neg = pre_val[PRE_W-1];
        pre_abs = pre_neg ? PRE_W'(-pre_val) : PRE_W'(pre_val);
    end

    // Stage-1 pipeline register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_dc    <= 1'b0;
            s1_pass  <= 1'b0;
            s1_neg   <= 1'b0;
            s1_mag   <= '0;
            s1_wgt   <= '0;
            s1_coef  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_dc    <= in_valid & in_dc;
            s1_pass  <= in_valid & in_dc & (mode == DQ_INTRA);
            s1_neg   <= pre_neg;
            s1_mag   <= pre_abs[COEF_W:0];
            s1_wgt   <= in_weight;
            s1_coef  <= in_coef;
        end
    end

    // A nonzero level must give a nonzero pre-scale of the same sign (R1, R2)
    p_prescale_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_coef != '0) |=> (s1_mag != '0) && (s1_neg == $past(in_coef[COEF_W-1])));

endmodule

// File: rtl/dq_magmul.sv
// Module dq_magmul (pipeline stage 2)
// Multiplies the pre-scaled magnitude by the unsigned weight. Forwards
// sign, bypass and marker state with the product.
// Assumes: magnitude and weight are unsigned.
module dq_magmul #(
    parameter int COEF_W = 8,
    parameter int WGT_W  = 16,
    localparam int PROD_W = COEF_W + 1 + WGT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s1_valid,
    input  logic               s1_dc,
    input  logic               s1_pass,
    input  logic               s1_neg,
    input  logic [COEF_W:0]    s1_mag,
    input  logic [WGT_W-1:0]   s1_wgt,
    input  logic [COEF_W-1:0]  s1_coef,
    output logic               s2_valid,
    output logic               s2_dc,
    output logic               s2_pass,
    output logic               s2_neg,
    output logic [PROD_W-1:0]  s2_prod,
    output logic [COEF_W-1:0]  s2_coef
);

    logic [PROD_W-1:0] prod;

    // Full-width unsigned product of magnitude and weight
    always_comb begin
        prod = PROD_W'(s1_mag) * PROD_W'(s1_wgt);
    end

    // Stage-2 pipeline register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_dc    <= 1'b0;
            s2_pass  <= 1'b0;
            s2_neg   <= 1'b0;
            s2_prod  <= '0;
            s2_coef  <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_dc    <= s1_dc;
            s2_pass  <= s1_pass;
            s2_neg   <= s1_neg;
            s2_prod  <= prod;
            s2_coef  <= s1_coef;
        end
    end

    // A zero magnitude or weight must yield a zero product (R8)
    p_zero_product_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && ((s1_mag == '0) || (s1_wgt == '0)) |=> (s2_prod == '0));

endmodule

// File: rtl/dq_finish.sv
// Module dq_finish (pipeline stage 3)
// Divides the magnitude by 16 with truncation, forces even nonzero results
// odd toward zero, restores the sign and saturates to OUT_W bits. Intra DC
// levels bypass all of this and are sign-extended.
// Assumes: the product magnitude is unsigned and the sign is carried apart,
// so the shift always truncates toward zero.
module dq_finish
    import dq_pkg::*;
#(
    parameter int COEF_W = 8,
    parameter int WGT_W  = 16,
    parameter int OUT_W  = 12,
    localparam int PROD_W = COEF_W + 1 + WGT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s2_valid,
    input  logic               s2_dc,
    input  logic               s2_pass,
    input  logic               s2_neg,
    input  logic [PROD_W-1:0]  s2_prod,
    input  logic [COEF_W-1:0]  s2_coef,
    output logic               out_valid,
    output logic               out_dc,
    output logic [OUT_W-1:0]   out_coef
);

    localparam int QW = PROD_W - DQ_DIV_SHIFT;
    localparam logic [QW-1:0] POS_LIM = QW'((1 << (OUT_W - 1)) - 1);
    localparam logic [QW-1:0] NEG_LIM = QW'(1 << (OUT_W - 1));
    localparam logic [OUT_W-1:0] POS_MAX = OUT_W'((1 << (OUT_W - 1)) - 1);
    localparam logic [OUT_W-1:0] NEG_MIN = OUT_W'(1 << (OUT_W - 1));

    logic [QW-1:0]    quo;
    logic [QW-1:0]    quo_odd;
    logic [OUT_W-1:0] low_bits;
    logic [OUT_W-1:0] result;
    logic             pass_q;

    // Truncating divide, odd forcing, sign restore and saturation
    always_comb begin
        quo = s2_prod[PROD_W-1:DQ_DIV_SHIFT];
        if ((quo != '0) && !quo[0])
            quo_odd = quo - QW'(1);
        else
            quo_odd = quo;
        low_bits = quo_odd[OUT_W-1:0];
        if (s2_pass)
            result = {{(OUT_W - COEF_W){s2_coef[COEF_W-1]}}, s2_coef};
        else if (!s2_neg)
            result = (quo_odd > POS_LIM) ? POS_MAX : low_bits;
        else
            result = (quo_odd > NEG_LIM) ? NEG_MIN : (~low_bits + OUT_W'(1));
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dc    <= 1'b0;
            out_coef  <= '0;
            pass_q    <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            out_dc    <= s2_dc;
            out_coef  <= result;
            pass_q    <= s2_pass;
        end
    end

    // Arithmetic outputs are odd unless zero or at the negative bound (R4)
    p_odd_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !pass_q && (out_coef != '0) && (out_coef != NEG_MIN) |-> out_coef[0]);

    // A positive product never leaves a negative result (R5)
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid && !s2_pass && !s2_neg |=> !out_coef[OUT_W-1]);

endmodule

// File: rtl/coef_dequant.sv
// Module coef_dequant (top)
// Three-stage coefficient reconstruction pipeline with a macroblock mode
// register. Stage 1 pre-scales, stage 2 multiplies, stage 3 divides,
// forces odd and saturates.
// Assumes: coefficients arrive in inverse-scan order with their scaled
// weight. mode_load is pulsed before the first coefficient of a macroblock.
module coef_dequant
    import dq_pkg::*;
#(
    parameter int COEF_W = 8,
    parameter int WGT_W  = 16,
    parameter int OUT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic              mode_intra,
    input  logic              in_valid,
    input  logic              in_dc,
    input  logic [COEF_W-1:0] in_coef,
    input  logic [WGT_W-1:0]  in_weight,
    output logic              out_valid,
    output logic              out_dc,
    output logic [OUT_W-1:0]  out_coef
);

    localparam int PROD_W = COEF_W + 1 + WGT_W;

    dq_mode_e          mode_q;
    logic              s1_valid, s1_dc, s1_pass, s1_neg;
    logic [COEF_W:0]   s1_mag;
    logic [WGT_W-1:0]  s1_wgt;
    logic [COEF_W-1:0] s1_coef;
    logic              s2_valid, s2_dc, s2_pass, s2_neg;
    logic [PROD_W-1:0] s2_prod;
    logic [COEF_W-1:0] s2_coef;

    // Macroblock mode register, loaded by strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= DQ_NONINTRA;
        else if (mode_load)
            mode_q <= mode_intra ? DQ_INTRA : DQ_NONINTRA;
    end

    dq_prescale #(.COEF_W(COEF_W), .WGT_W(WGT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .mode(mode_q),
        .in_valid(in_valid), .in_dc(in_dc),
        .in_coef($signed(in_coef)), .in_weight(in_weight),
        .s1_valid(s1_valid), .s1_dc(s1_dc), .s1_pass(s1_pass),
        .s1_neg(s1_neg), .s1_mag(s1_mag), .s1_wgt(s1_wgt), .s1_coef(s1_coef)
    );

    dq_magmul #(.COEF_W(COEF_W), .WGT_W(WGT_W)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_dc(s1_dc), .s1_pass(s1_pass),
        .s1_neg(s1_neg), .s1_mag(s1_mag), .s1_wgt(s1_wgt), .s1_coef(s1_coef),
        .s2_valid(s2_valid), .s2_dc(s2_dc), .s2_pass(s2_pass),
        .s2_neg(s2_neg), .s2_prod(s2_prod), .s2_coef(s2_coef)
    );

    dq_finish #(.COEF_W(COEF_W), .WGT_W(WGT_W), .OUT_W(OUT_W)) u_fin (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_dc(s2_dc), .s2_pass(s2_pass),
        .s2_neg(s2_neg), .s2_prod(s2_prod), .s2_coef(s2_coef),
        .out_valid(out_valid), .out_dc(out_dc), .out_coef(out_coef)
    );

    // Mode changes only on the load strobe (R6)
    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode_q));

    // Loaded mode equals the strobed value (R6)
    p_mode_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> (mode_q == ($past(mode_intra) ? DQ_INTRA : DQ_NONINTRA)));

    // Valid appears exactly three cycles later (R9)
    p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // No spurious valid three cycles after an idle input (R9)
    p_idle_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // DC marker travels with its coefficient (R9)
    p_dc_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_dc |-> ##3 out_dc);

    // Zero level gives zero output in either mode (R8)
    p_zero_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_coef == '0) |-> ##3 (out_coef == '0));

    // Intra DC bypass delivers the level sign-extended (R7)
    p_dc_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_dc && (mode_q == DQ_INTRA) |-> ##3
        (out_coef == {{(OUT_W - COEF_W){$past(in_coef[COEF_W-1], 3)}}, $past(in_coef, 3)}));

endmodule

// File: tb/coef_dequant_tb.sv
// Bench for coef_dequant: directed corners plus seeded random stimulus,
// compared against a reference function built from the requirements.
module coef_dequant_tb;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic        mode_intra = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_dc = 1'b0;
    logic [7:0]  in_coef = '0;
    logic [15:0] in_weight = '0;
    logic        out_valid;
    logic        out_dc;
    logic [11:0] out_coef;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit model_intra = 1'b0;

    // Expected-result pipeline (3 entries)
    bit          pv [3];
    bit          pd [3];
    int          pe [3];
    string       pr [3];

    always #(CLK_PERIOD / 2) clk = ~clk;

    coef_dequant u_dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_intra(mode_intra),
        .in_valid(in_valid), .in_dc(in_dc), .in_coef(in_coef), .in_weight(in_weight),
        .out_valid(out_valid), .out_dc(out_dc), .out_coef(out_coef)
    );

    function automatic int sgn(longint v);
        return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
    endfunction

    // Reference reconstruction from the requirements
    function automatic int ref_val(int c, int w, bit intra, bit dc);
        longint p, q;
        if (intra && dc) return c;                  // R7
        p = intra ? 2 * c : 2 * c + sgn(c);         // R1, R2
        q = (p * w) / 16;                           // R3: truncates toward zero
        if (q != 0 && (q % 2) == 0) q = q - sgn(q); // R4
        if (q > 2047) q = 2047;                     // R5
        if (q < -2048) q = -2048;
        return int'(q);
    endfunction

    task automatic check(string req, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: compare the result due now, then drive a new input
    task automatic step(bit v, int c, int w, bit dc, bit ld, bit ld_intra, string req);
        @(negedge clk);
        if (pv[2] || (pr[2] != "")) begin
            check({pr[2], " valid"}, out_valid == pv[2], int'(out_valid), int'(pv[2]));
            if (pv[2]) begin
                check({pr[2], " data"}, $signed(out_coef) == pe[2], int'($signed(out_coef)), pe[2]);
                check({pr[2], " R9 dc"}, out_dc == pd[2], int'(out_dc), int'(pd[2]));
            end
        end
        for (int k = 2; k > 0; k--) begin
            pv[k] = pv[k-1]; pd[k] = pd[k-1]; pe[k] = pe[k-1]; pr[k] = pr[k-1];
        end
        pv[0] = v; pd[0] = v & dc; pr[0] = req;
        pe[0] = v ? ref_val(c, w, model_intra, dc) : 0;
        in_valid = v; in_dc = dc; in_coef = 8'(c); in_weight = 16'(w);
        mode_load = ld; mode_intra = ld_intra;
        if (ld) model_intra = ld_intra;   // R6: applies from the next cycle
    endtask

    task automatic set_mode(bit intra);
        step(1'b0, 0, 0, 1'b0, 1'b1, intra, "R6");
    endtask

    task automatic coef(int c, int w, bit dc, string req);
        step(1'b1, c, w, dc, 1'b0, 1'b0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) begin pv[k] = 0; pd[k] = 0; pe[k] = 0; pr[k] = ""; end
        in_valid = 1'b1; in_dc = 1'b1; in_coef = 8'd5; in_weight = 16'd99;
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10 valid", out_valid == 1'b0, int'(out_valid), 0);
        check("R10 dc", out_dc == 1'b0, int'(out_dc), 0);
        check("R10 data", out_coef == '0, int'(out_coef), 0);
        in_valid = 1'b0; in_dc = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // After reset the mode is non-intra: DC marker ignored (R10, R2)
        coef(5, 16, 1'b1, "R10 mode/R2");

        set_mode(1'b1);
        coef(1, 8, 1'b0, "R1");      // 16/16=1
        coef(1, 16, 1'b0, "R4");     // 2 -> 1
        coef(-1, 16, 1'b0, "R4");    // -2 -> -1
        coef(-3, 11, 1'b0, "R3");    // -66/16 -> -4 -> -3
        coef(0, 65535, 1'b0, "R8");
        coef(-100, 77, 1'b1, "R7");
        coef(127, 65535, 1'b0, "R5");
        coef(-128, 65535, 1'b0, "R5");
        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, "R9 idle");
        coef(4, 8, 1'b1, "R7");

        set_mode(1'b0);
        coef(1, 16, 1'b0, "R2");     // 3
        coef(-3, 11, 1'b0, "R2");    // -7*11=-77/16=-4 -> -3
        coef(0, 1234, 1'b0, "R8");
        coef(5, 16, 1'b1, "R2 dc ignored");
        coef(-128, 65535, 1'b0, "R5");
        coef(127, 300, 1'b0, "R5");
        // Mode load in same cycle as a coefficient: old mode still applies
        step(1'b1, 3, 16, 1'b0, 1'b1, 1'b1, "R6");
        coef(3, 16, 1'b0, "R6");

        for (int n = 0; n < 3000; n++) begin
            if (($urandom % 16) == 0)
                set_mode(1'($urandom));
            else if (($urandom % 8) == 0)
                step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, "R9 idle");
            else
                coef($signed(8'($urandom)), (($urandom % 4) == 0) ? int'($urandom % 65536) : int'($urandom % 600),
                     (($urandom % 5) == 0), "R3 random");
        end
        repeat (4) step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, "R9 drain");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule